// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Receiver with Sleep and Wakeup

This block receives asynchronous serial characters for a node on a shared multidrop line. Each character is 11 bits long: a low start bit, eight data bits sent least significant bit first, a ninth bit that tells an address character from a data character, and a high stop bit. The line is sampled by a 16x oversample tick. Every bit is taken at its centre, and a start bit counts only if the line is still low half a bit after the falling edge. A received character goes into a holding register. This raises a full flag and an interrupt request, and a read strobe clears both.

To skip traffic meant for other nodes, software pulses a sleep request. While asleep, the receiver still tracks characters on the line, but none of them reaches the holding register or touches the flags. Two wakeup conditions are available. In idle-line mode the node wakes after ten bit times of continuous high line. In address mode it wakes on a character whose ninth bit is 1, and that character becomes the first one delivered. Hardware clears the sleep state on wakeup. Software can put the node back to sleep at any point to skip the rest of a message.

Top module: `mdrop_rx`

## Requirements
- R1: A frame is a start bit (0), data bits d0..d7 with d0 first, then the ninth bit, then a stop bit, each lasting 16 os_tick periods and sampled at its centre. After a delivered frame, rx_data holds d7..d0 and rx_ninth holds the ninth bit.
- R2: A low pulse on rxd that has returned high by the start-bit midpoint (8 ticks) starts no frame and changes no output.
- R3: frame_err is updated with every delivered frame: 1 if the stop bit sampled low, 0 if it sampled high.
- R4: Delivering a frame sets rx_full. rx_irq is high exactly when rx_full is high. A rd_strobe pulse clears rx_full.
- R5: A frame that would be delivered while rx_full is set and no rd_strobe is present sets overrun and leaves rx_data and rx_ninth unchanged. rd_strobe clears overrun.
- R6: A sleep_set pulse makes sleeping 1 on the next cycle. While sleeping, frames that do not wake the node leave rx_data, rx_ninth, rx_full, frame_err and overrun unchanged.
- R7: With wake_addr = 0, a sleeping node wakes (sleeping returns to 0) after 160 consecutive ticks of high line with no frame in progress. The count restarts on sleep_set and at the end of each frame. The next frame is then delivered.
- R8: With wake_addr = 1, a sleeping node ignores frames whose ninth bit is 0 and does not wake on an idle line. A frame whose ninth bit is 1 clears sleeping and is delivered.
- R9: A sleep_set given after a delivered frame makes the following frames of that message be ignored.
- R10: While rx_en is low, no frame starts and nothing is delivered.
- R11: If rx_en goes low after a frame has started, that frame is still completed and delivered.
- R12: rx_en low does not clear rx_full or rx_irq.
- R13: After reset, all outputs are 0, including sleeping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| os_tick | input | 1 | Oversample tick, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable; gates the start of new frames |
| wake_addr | input | 1 | Wakeup mode: 0 idle line, 1 address bit |
| sleep_set | input | 1 | Pulse that puts the receiver to sleep |
| rd_strobe | input | 1 | Read strobe for the holding register; clears full and overrun |
| rx_data | output | 8 | Received data byte |
| rx_ninth | output | 1 | Ninth (address) bit of the received frame |
| rx_full | output | 1 | Holding register contains an unread frame |
| rx_irq | output | 1 | Receive interrupt request |
| frame_err | output | 1 | Stop bit of the last delivered frame sampled low |
| overrun | output | 1 | A frame was lost because the register was still full |
| sleeping | output | 1 | Receiver is asleep, waiting for its wakeup condition |

## Verification
The assertions assume that sleep_set and rd_strobe are single-cycle pulses. They also assume that rxd holds each bit for a full 16 ticks, so a frame's sampled values follow what was driven. The bench drives every input at the falling clock edge and keeps os_tick permanently high. Every frame it sends lasts exactly 176 ticks, and each frame is followed by at least 20 cycles of idle line. A stop bit driven low is followed by a high line, so the false start it causes is always aborted at the start-bit midpoint.

// File: rtl/mdrop_pkg.sv
`timescale 1ns/1ps
package mdrop_pkg;
  // Receive sequencer phases
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_SHIFT = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/mdrop_sync.sv
`timescale 1ns/1ps
module mdrop_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= {sr_q[STAGES-2:0], d};
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/mdrop_frame.sv
`timescale 1ns/1ps
module mdrop_frame
  import mdrop_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int NBITS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxd_s,
  input  logic             en,
  output logic             busy,
  output logic             done,
  output logic [NBITS-1:0] bits,
  output logic             stop_ok
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(NBITS);
  localparam logic [CW-1:0] LAST_T = CW'(OSR - 1);
  localparam logic [CW-1:0] MID_T  = CW'(OSR / 2 - 1);
  localparam logic [BW-1:0] LAST_B = BW'(NBITS - 1);

  rx_state_t        state_q, state_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic [BW-1:0]    idx_q, idx_n;
  logic [NBITS-1:0] sh_q, sh_n;
  logic             done_q, done_n;
  logic             stop_q, stop_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    sh_n    = sh_q;
    done_n  = 1'b0;
    stop_n  = stop_q;
    if (tick) begin
      case (state_q)
        RX_IDLE: begin
          if (en && !rxd_s) begin
            state_n = RX_START;
            cnt_n   = '0;
          end
        end
        RX_START: begin
          if (cnt_q == MID_T) begin
            cnt_n   = '0;
            idx_n   = '0;
            state_n = rxd_s ? RX_IDLE : RX_SHIFT;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_SHIFT: begin
          if (cnt_q == LAST_T) begin
            cnt_n = '0;
            sh_n  = {rxd_s, sh_q[NBITS-1:1]};
            if (idx_q == LAST_B) state_n = RX_STOP;
            else                 idx_n   = idx_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == LAST_T) begin
            cnt_n   = '0;
            done_n  = 1'b1;
            stop_n  = rxd_s;
            state_n = RX_IDLE;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: state_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
      stop_q  <= 1'b1;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      sh_q    <= sh_n;
      done_q  <= done_n;
      stop_q  <= stop_n;
    end
  end

  assign busy    = (state_q != RX_IDLE);
  assign done    = done_q;
  assign bits    = sh_q;
  assign stop_ok = stop_q;
endmodule

// File: rtl/mdrop_idle.sv
`timescale 1ns/1ps
module mdrop_idle #(
  parameter int OSR       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd_s,
  input  logic busy,
  input  logic restart,
  output logic idle_seen
);
  localparam int LIMIT = OSR * IDLE_BITS;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (restart || busy || !rxd_s)  cnt_n = '0;
    else if (tick && cnt_q != LIM)  cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign idle_seen = (cnt_q == LIM);
endmodule

// File: rtl/mdrop_rx.sv
`timescale 1ns/1ps
module mdrop_rx #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 8,
  parameter int IDLE_BITS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              wake_addr,
  input  logic              sleep_set,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ninth,
  output logic              rx_full,
  output logic              rx_irq,
  output logic              frame_err,
  output logic              overrun,
  output logic              sleeping
);
  localparam int NBITS = DATA_W + 1;

  logic             rst_q_n;
  logic             rxd_s;
  logic             fr_busy, fr_done, fr_stop_ok, fr_ninth, idle_seen;
  logic [NBITS-1:0] fr_bits;

  // Reset: asserted asynchronously, released through two flops
  mdrop_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q_n)
  );

  mdrop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_q_n), .d(rxd), .q(rxd_s)
  );

  mdrop_frame #(.OSR(OSR), .NBITS(NBITS)) u_frame (
    .clk(clk), .rst_n(rst_q_n), .tick(os_tick), .rxd_s(rxd_s), .en(rx_en),
    .busy(fr_busy), .done(fr_done), .bits(fr_bits), .stop_ok(fr_stop_ok)
  );

  mdrop_idle #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_q_n), .tick(os_tick), .rxd_s(rxd_s),
    .busy(fr_busy), .restart(sleep_set), .idle_seen(idle_seen)
  );

  assign fr_ninth = fr_bits[NBITS-1];

  // Sleep control
  logic sleep_q, sleep_n, sleep_en;
  logic wake_by_addr, wake_by_idle, accept;

  assign wake_by_addr = fr_done && wake_addr && fr_ninth;
  assign wake_by_idle = !wake_addr && idle_seen;
  assign accept       = fr_done && (!sleep_q || wake_by_addr);

  always_comb begin
    sleep_en = 1'b0;
    sleep_n  = sleep_q;
    if (sleep_set) begin
      sleep_en = 1'b1;
      sleep_n  = 1'b1;
    end else if (sleep_q && (wake_by_idle || wake_by_addr)) begin
      sleep_en = 1'b1;
      sleep_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      sleep_q <= 1'b0;
    else if (sleep_en) sleep_q <= sleep_n;
  end

  // Holding register and status flags
  logic              full_q, full_n, ovr_q, ovr_n, flag_en, load_en;
  logic [DATA_W-1:0] data_q;
  logic              ninth_q, ferr_q;

  always_comb begin
    full_n  = full_q;
    ovr_n   = ovr_q;
    load_en = 1'b0;
    if (rd_strobe) begin
      full_n = 1'b0;
      ovr_n  = 1'b0;
    end
    if (accept) begin
      if (full_q && !rd_strobe) begin
        ovr_n = 1'b1;
      end else begin
        load_en = 1'b1;
        full_n  = 1'b1;
      end
    end
    flag_en = rd_strobe || accept;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (flag_en) begin
      full_q <= full_n;
      ovr_q  <= ovr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      data_q  <= '0;
      ninth_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else if (load_en) begin
      data_q  <= fr_bits[DATA_W-1:0];
      ninth_q <= fr_ninth;
      ferr_q  <= !fr_stop_ok;
    end
  end

  assign rx_data   = data_q;
  assign rx_ninth  = ninth_q;
  assign rx_full   = full_q;
  assign rx_irq    = full_q;
  assign frame_err = ferr_q;
  assign overrun   = ovr_q;
  assign sleeping  = sleep_q;
endmodule

// File: rtl/mdrop_rx_chk.sv
`timescale 1ns/1ps
module mdrop_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_set,
  input logic              rd_strobe,
  input logic              wake_addr,
  input logic              rx_en,
  input logic              frame_done,
  input logic              frame_ninth,
  input logic              frame_busy,
  input logic              idle_seen,
  input logic              rx_full,
  input logic              overrun,
  input logic              sleeping,
  input logic [DATA_W-1:0] rx_data
);
  // R4
  rd_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !frame_done |=> !rx_full && !overrun);

  // R5
  overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !sleeping && rx_full && !rd_strobe |=> overrun && $stable(rx_data));

  // R6
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_set |=> sleeping);

  // R6
  asleep_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping && frame_done && !(wake_addr && frame_ninth) && !rd_strobe
    |=> $stable(rx_data) && $stable(rx_full));

  // R7
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping && !wake_addr && idle_seen && !sleep_set |=> !sleeping);

  // R8
  addr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping && wake_addr && frame_done && frame_ninth && !sleep_set
    |=> !sleeping && rx_full);

  // R10
  start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_busy) |-> $past(rx_en));

  // R12
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && !rd_strobe |=> rx_full);
endmodule

bind mdrop_rx mdrop_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .sleep_set(sleep_set), .rd_strobe(rd_strobe),
  .wake_addr(wake_addr), .rx_en(rx_en), .frame_done(fr_done),
  .frame_ninth(fr_ninth), .frame_busy(fr_busy), .idle_seen(idle_seen),
  .rx_full(rx_full), .overrun(overrun), .sleeping(sleeping), .rx_data(rx_data)
);

// File: tb/tb_mdrop_rx.sv
`timescale 1ns/1ps
module tb_mdrop_rx;
  localparam int OSR = 16;
  localparam int LIM = 160;

  logic clk = 1'b0;
  logic rst_n, os_tick, rxd, rx_en, wake_addr, sleep_set, rd_strobe;
  logic [7:0] rx_data;
  logic rx_ninth, rx_full, rx_irq, frame_err, overrun, sleeping;

  always #2.5 clk = ~clk;

  mdrop_rx dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .rx_en(rx_en),
    .wake_addr(wake_addr), .sleep_set(sleep_set), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_ninth(rx_ninth), .rx_full(rx_full), .rx_irq(rx_irq),
    .frame_err(frame_err), .overrun(overrun), .sleeping(sleeping)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string req = "R13";

  // Behavioural reference state
  bit [7:0] m_data = '0;
  bit m_ninth = 0, m_full = 0, m_ferr = 0, m_ovr = 0, m_sleep = 0;
  int m_phase = -1;
  int m_icnt = 0;
  bit h1 = 1, h2 = 1;
  bit m_done = 0;
  bit [8:0] m_bits = '0;
  bit m_stop = 1;

  function automatic void model_step();
    bit rs, seen, wake, deliver, n_done;
    int p, n_phase, n_icnt;
    rs = h2;
    seen = (m_icnt == LIM);
    wake = m_done && wake_addr && m_bits[8];
    deliver = m_done && (!m_sleep || wake);
    if (sleep_set || m_phase >= 0 || !rs) n_icnt = 0;
    else if (os_tick && m_icnt < LIM)     n_icnt = m_icnt + 1;
    else                                  n_icnt = m_icnt;
    if (rd_strobe) begin m_full = 0; m_ovr = 0; end
    if (deliver) begin
      if (m_full) m_ovr = 1;
      else begin
        m_data = m_bits[7:0]; m_ninth = m_bits[8]; m_ferr = !m_stop; m_full = 1; m_ovr = 0;
      end
    end
    if (sleep_set) m_sleep = 1;
    else if (m_sleep && ((!wake_addr && seen) || wake)) m_sleep = 0;
    n_done = 0;
    n_phase = m_phase;
    if (os_tick) begin
      if (m_phase < 0) begin
        if (rx_en && !rs) n_phase = 0;
      end else begin
        p = m_phase + 1;
        n_phase = p;
        if (p == OSR/2) begin
          if (rs) n_phase = -1;
        end else if (p > OSR/2 && (p - OSR/2) % OSR == 0) begin
          if ((p - OSR/2) / OSR <= 9) m_bits[(p - OSR/2) / OSR - 1] = rs;
          else begin m_stop = rs; n_done = 1; n_phase = -1; end
        end
      end
    end
    m_phase = n_phase;
    m_icnt = n_icnt;
    m_done = n_done;
    h2 = h1;
    h1 = rxd;
  endfunction

  task automatic compare();
    logic [13:0] a, e;
    a = {rx_data, rx_ninth, rx_full, rx_irq, frame_err, overrun, sleeping};
    e = {m_data, m_ninth, m_full, m_full, m_ferr, m_ovr, m_sleep};
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s: outputs act=%h exp=%h", req, a, e);
    end
  endtask

  task automatic expect_val(string r, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: %s act=%0h exp=%0h", r, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    sleep_set = 0;
    rd_strobe = 0;
  endtask

  task automatic idle(int n);
    rxd = 1;
    repeat (n) cyc();
  endtask

  task automatic send(input logic [8:0] v, input logic stop_b, input int drop_at);
    for (int j = 0; j < 11; j++) begin
      for (int t = 0; t < OSR; t++) begin
        if (j == 0)       rxd = 0;
        else if (j == 10) rxd = stop_b;
        else              rxd = v[j-1];
        if (drop_at == j*OSR + t) rx_en = 0;
        cyc();
      end
    end
    rxd = 1;
    idle(24);
  endtask

  task automatic rd();
    rd_strobe = 1;
    cyc();
  endtask

  task automatic sleep();
    sleep_set = 1;
    cyc();
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; os_tick = 1; rxd = 1; rx_en = 1; wake_addr = 0; sleep_set = 0; rd_strobe = 0;
    repeat (4) @(negedge clk);
    // R13 reset state
    expect_val("R13", {rx_data, rx_ninth, rx_full, rx_irq, frame_err, overrun, sleeping}, 0, "outputs in reset");
    rst_n = 1;
    idle(8);
    expect_val("R13", int'(sleeping), 0, "sleeping after reset");

    req = "R1";
    send(9'h0A5, 1, -1);
    expect_val("R1", rx_data, 8'hA5, "data");
    expect_val("R1", rx_ninth, 0, "ninth");
    expect_val("R4", rx_irq, 1, "irq");
    req = "R4"; rd(); idle(2);
    expect_val("R4", rx_full, 0, "full after read");
    req = "R1";
    send(9'h13C, 1, -1);
    expect_val("R1", rx_data, 8'h3C, "data");
    expect_val("R1", rx_ninth, 1, "ninth");
    rd();

    req = "R3";
    send(9'h066, 0, -1);
    expect_val("R3", frame_err, 1, "ferr on low stop");
    rd();
    send(9'h099, 1, -1);
    expect_val("R3", frame_err, 0, "ferr on good stop");

    req = "R5";
    send(9'h111, 1, -1);
    expect_val("R5", overrun, 1, "overrun");
    expect_val("R5", rx_data, 8'h99, "data kept");
    rd(); idle(2);
    expect_val("R5", overrun, 0, "overrun after read");

    req = "R2";
    rxd = 0; repeat (5) cyc();
    idle(40);
    expect_val("R2", rx_full, 0, "glitch ignored");

    req = "R10";
    rx_en = 0;
    send(9'h0F0, 1, -1);
    expect_val("R10", rx_full, 0, "disabled receiver");

    req = "R11";
    rx_en = 1;
    send(9'h05A, 1, 3*OSR);
    expect_val("R11", rx_data, 8'h5A, "frame completed after disable");
    req = "R12";
    idle(50);
    expect_val("R12", rx_irq, 1, "irq held while disabled");
    rd(); rx_en = 1; idle(4);

    req = "R8";
    wake_addr = 1;
    sleep(); idle(4);
    send(9'h055, 1, -1);
    expect_val("R6", rx_full, 0, "asleep frame ignored");
    idle(300);
    expect_val("R8", sleeping, 1, "no idle wake in address mode");
    send(9'h1AA, 1, -1);
    expect_val("R8", sleeping, 0, "woke on address");
    expect_val("R8", rx_data, 8'hAA, "address frame delivered");
    req = "R9";
    rd(); sleep();
    send(9'h077, 1, -1);
    expect_val("R9", rx_full, 0, "rest of message ignored");
    expect_val("R9", rx_data, 8'hAA, "data unchanged");

    req = "R7";
    wake_addr = 0;
    sleep(); idle(20);
    send(9'h042, 1, -1);
    expect_val("R7", rx_full, 0, "ignored before idle");
    idle(76);
    expect_val("R7", sleeping, 1, "still asleep under 160 ticks");
    idle(70);
    expect_val("R7", sleeping, 0, "woke after idle line");
    send(9'h0C3, 1, -1);
    expect_val("R7", rx_data, 8'hC3, "frame after idle wake");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule